// File: doc/BRIEF.md
# Serial Three-Register Load Interface

This block is a write-only serial slave that fills three byte-wide configuration registers for a pulse generator: a control byte, an output period byte and a high-time byte. A host selects the block with an active-low select line, clocks bits in on a serial clock that idles low, and releases select. Every serial pin is brought into the system clock domain through synchronizer flops. All edge detection and register updates happen on the system clock.

The length of the transfer decides what the release of select does. Twenty-four bits rewrite all three registers. Sixteen bits rewrite the period and the high time. Eight bits rewrite only the high time. Any other length is thrown away. The control byte holds a clock-divide select and a power-down bit. Power-down can only be cleared by a full-length write. A `configured` flag shows that a full write has happened since reset, and a one-cycle strobe marks every accepted commit.

Top module: `swl_load_if`

## Requirements
- R1: After reset, `div2`, `pdown`, `period`, `width`, `configured` and `load_stb` are all zero.
- R2: A bit is taken from `sdi` on each rising edge of `sclk` while `cs_n` is low, most significant bit first, so the first bit sent lands in bit 7 of its byte.
- R3: On release of `cs_n` after exactly 24 bits, the first byte goes to control, the second byte to `period` and the third byte to `width`.
- R4: On release after exactly 16 bits, the first byte goes to `period` and the second to `width`; `div2` and `pdown` keep their values.
- R5: On release after exactly 8 bits, the byte goes to `width`; `period`, `div2` and `pdown` keep their values.
- R6: On release after any other number of bits (including more than 24), no output register changes and `load_stb` stays low.
- R7: Control bit 0 drives `div2` (1 = divide by two) and control bit 1 drives `pdown` (1 = power down); control bits 7..2 affect no output.
- R8: `configured` stays low until the first 24-bit commit, goes high with it, and never falls again before the next reset.
- R9: Once `pdown` is set, 8-bit and 16-bit commits leave it set; only a 24-bit commit with control bit 1 clear clears it.
- R10: Each accepted commit raises `load_stb` for exactly one system clock cycle, in the same cycle in which the new register values appear.
- R11: While `cs_n` stays low, no output register changes, however many bits have been shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, asynchronous to `clk` |
| sclk | input | 1 | Serial clock, idles low, asynchronous to `clk` |
| sdi | input | 1 | Serial data, MSB first |
| div2 | output | 1 | Clock divide-by-two select (control bit 0) |
| pdown | output | 1 | Power-down request (control bit 1) |
| period | output | 8 | Period register |
| width | output | 8 | High-time register |
| configured | output | 1 | A full 24-bit write has been committed since reset |
| load_stb | output | 1 | One-cycle pulse on each accepted commit |

## Verification
The assertions check three things on every cycle. No output register and no `configured` change can occur without `load_stb`. `configured` never falls. The strobe never lasts two cycles. None of this shows whether the right byte reached the right register, or whether the bit count was decoded correctly. Those questions, along with MSB-first ordering, discarding of odd lengths, and the power-down bit surviving short writes, are covered only by the bench's directed transfers, which compare each register against values derived from the bits that were sent.

// File: rtl/swl_pkg.sv
package swl_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_BYTES = 3;
  localparam int unsigned CHAIN_W = BYTE_W * N_BYTES;
  localparam int unsigned CNT_W   = $clog2(CHAIN_W + 2);

  typedef enum logic [1:0] {
    CMT_NONE  = 2'd0,
    CMT_WIDTH = 2'd1,
    CMT_PW    = 2'd2,
    CMT_FULL  = 2'd3
  } commit_e;
endpackage

// File: rtl/swl_sync.sv
module swl_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb pipe_d = {pipe_q[STAGES-2:0], din[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL[g]}};
      else        pipe_q <= pipe_d;
    end

    assign dout[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/swl_shift.sv
module swl_shift
  import swl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [CHAIN_W-1:0] chain,
  output logic [CNT_W-1:0]   count
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CHAIN_W + 1);

  logic [CHAIN_W-1:0] chain_d;
  logic [CNT_W-1:0]   count_d;
  logic               chain_en;
  logic               count_en;

  always_comb begin
    chain_en = shift_en;
    chain_d  = {chain[CHAIN_W-2:0], bit_in};
    count_en = start | shift_en;
    if (start)                  count_d = '0;
    else if (count == CNT_SAT)  count_d = count;
    else                        count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      count <= '0;
    end else begin
      if (chain_en) chain <= chain_d;
      if (count_en) count <= count_d;
    end
  end
endmodule

// File: rtl/swl_commit.sv
module swl_commit
  import swl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               end_evt,
  input  logic [CHAIN_W-1:0] chain,
  input  logic [CNT_W-1:0]   count,
  output logic               div2,
  output logic               pdown,
  output logic [BYTE_W-1:0]  period,
  output logic [BYTE_W-1:0]  width,
  output logic               configured,
  output logic               load_stb
);
  commit_e           kind;
  logic [BYTE_W-1:0] b_last, b_mid, b_first;
  logic              div2_d, pdown_d, cfg_d, stb_d;
  logic [BYTE_W-1:0] period_d, width_d;
  logic              unused_ctrl_hi;

  assign b_last  = chain[BYTE_W-1:0];
  assign b_mid   = chain[2*BYTE_W-1:BYTE_W];
  assign b_first = chain[3*BYTE_W-1:2*BYTE_W];
  assign unused_ctrl_hi = ^b_first[BYTE_W-1:2];

  always_comb begin
    kind = CMT_NONE;
    if (end_evt) begin
      if      (count == CNT_W'(BYTE_W))     kind = CMT_WIDTH;
      else if (count == CNT_W'(2 * BYTE_W)) kind = CMT_PW;
      else if (count == CNT_W'(3 * BYTE_W)) kind = CMT_FULL;
    end
  end

  always_comb begin
    div2_d   = div2;
    pdown_d  = pdown;
    period_d = period;
    width_d  = width;
    cfg_d    = configured;
    stb_d    = 1'b0;
    unique case (kind)
      CMT_WIDTH: begin
        width_d = b_last;
        stb_d   = 1'b1;
      end
      CMT_PW: begin
        period_d = b_mid;
        width_d  = b_last;
        stb_d    = 1'b1;
      end
      CMT_FULL: begin
        div2_d   = b_first[0];
        pdown_d  = b_first[1];
        period_d = b_mid;
        width_d  = b_last;
        cfg_d    = 1'b1;
        stb_d    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div2       <= 1'b0;
      pdown      <= 1'b0;
      period     <= '0;
      width      <= '0;
      configured <= 1'b0;
      load_stb   <= 1'b0;
    end else begin
      div2       <= div2_d;
      pdown      <= pdown_d;
      period     <= period_d;
      width      <= width_d;
      configured <= cfg_d;
      load_stb   <= stb_d;
    end
  end
endmodule

// File: rtl/swl_load_if.sv
module swl_load_if
  import swl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              div2,
  output logic              pdown,
  output logic [BYTE_W-1:0] period,
  output logic [BYTE_W-1:0] width,
  output logic              configured,
  output logic              load_stb
);
  logic [2:0]         raw_pins, sync_pins;
  logic               cs_s, sck_s, sdi_s;
  logic               cs_q, sck_q;
  logic               start_evt, end_evt, shift_evt;
  logic [CHAIN_W-1:0] chain;
  logic [CNT_W-1:0]   count;

  assign raw_pins = {cs_n, sclk, sdi};

  swl_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_pins),
    .dout  (sync_pins)
  );

  assign {cs_s, sck_s, sdi_s} = sync_pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign start_evt = cs_q & ~cs_s;
  assign end_evt   = ~cs_q & cs_s;
  assign shift_evt = ~cs_s & sck_s & ~sck_q;

  swl_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .shift_en (shift_evt),
    .bit_in   (sdi_s),
    .chain    (chain),
    .count    (count)
  );

  swl_commit u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .end_evt    (end_evt),
    .chain      (chain),
    .count      (count),
    .div2       (div2),
    .pdown      (pdown),
    .period     (period),
    .width      (width),
    .configured (configured),
    .load_stb   (load_stb)
  );
endmodule

// File: rtl/swl_load_if_chk.sv
module swl_load_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       div2,
  input logic       pdown,
  input logic [7:0] period,
  input logic [7:0] width,
  input logic       configured,
  input logic       load_stb
);
  // R10
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  // R8
  cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(configured));

  // R8
  cfg_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured) |-> load_stb);

  // R9
  pdown_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pdown) |-> load_stb);

  // R7
  div2_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div2) |-> load_stb);

  // R4
  period_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(period) |-> load_stb);

  // R5
  width_with_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(width) |-> load_stb);
endmodule

bind swl_load_if swl_load_if_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .div2       (div2),
  .pdown      (pdown),
  .period     (period),
  .width      (width),
  .configured (configured),
  .load_stb   (load_stb)
);

// File: tb/tb_swl_load_if.sv
module tb_swl_load_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       div2, pdown, configured, load_stb;
  logic [7:0] period, width;

  int errors = 0;
  int checks = 0;
  int stb_cnt = 0;
  int stb_long = 0;
  logic stb_prev = 1'b0;

  always #2.5 clk = ~clk;

  swl_load_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .div2(div2), .pdown(pdown), .period(period), .width(width),
    .configured(configured), .load_stb(load_stb)
  );

  always @(posedge clk) begin
    stb_prev <= load_stb;
    if (load_stb) stb_cnt <= stb_cnt + 1;
    if (load_stb && stb_prev) stb_long <= stb_long + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input int n, input logic [31:0] data);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = data[i];
      waitc(4);
      sclk = 1'b1;
      waitc(4);
      sclk = 1'b0;
    end
  endtask

  task automatic send(input int n, input logic [31:0] data);
    cs_n = 1'b0;
    waitc(4);
    shift_bits(n, data);
    waitc(4);
    cs_n = 1'b1;
    waitc(8);
  endtask

  task automatic expect_regs(input string req, input logic d2, input logic pd,
                             input logic [7:0] p, input logic [7:0] w);
    check({req, " div2"}, 32'(div2), 32'(d2));
    check({req, " pdown"}, 32'(pdown), 32'(pd));
    check({req, " period"}, 32'(period), 32'(p));
    check({req, " width"}, 32'(width), 32'(w));
  endtask

  task automatic t_reset;
    // R1
    expect_regs("R1", 1'b0, 1'b0, 8'h00, 8'h00);
    check("R1 configured", 32'(configured), 0);
    check("R1 load_stb", 32'(load_stb), 0);
  endtask

  task automatic t_short_before_full;
    int s0;
    s0 = stb_cnt;
    send(16, 32'h0000_12C4);
    // R4 R2: first byte to period, MSB first
    expect_regs("R4", 1'b0, 1'b0, 8'h12, 8'hC4);
    // R8: still not configured
    check("R8 not configured", 32'(configured), 0);
    check("R10 one strobe", 32'(stb_cnt - s0), 1);
  endtask

  task automatic t_full;
    int s0;
    s0 = stb_cnt;
    send(24, 32'h00FD_0583);
    // R3 R7: ctrl 0xFD -> div2=1, pdown=0, upper bits ignored
    expect_regs("R3/R7", 1'b1, 1'b0, 8'h05, 8'h83);
    check("R8 configured", 32'(configured), 1);
    check("R10 one strobe", 32'(stb_cnt - s0), 1);
  endtask

  task automatic t_width_only;
    send(8, 32'h0000_00A6);
    // R5
    expect_regs("R5", 1'b1, 1'b0, 8'h05, 8'hA6);
  endtask

  task automatic t_bad_lengths;
    int s0;
    s0 = stb_cnt;
    send(12, 32'h0000_0FFF);
    // R6
    expect_regs("R6 12 bits", 1'b1, 1'b0, 8'h05, 8'hA6);
    send(25, 32'h01FF_FFFF);
    expect_regs("R6 25 bits", 1'b1, 1'b0, 8'h05, 8'hA6);
    send(0, 32'h0);
    expect_regs("R6 0 bits", 1'b1, 1'b0, 8'h05, 8'hA6);
    check("R6 no strobe", 32'(stb_cnt - s0), 0);
    check("R8 stays", 32'(configured), 1);
  endtask

  task automatic t_mid_transfer;
    cs_n = 1'b0;
    waitc(4);
    shift_bits(8, 32'h0000_0033);
    waitc(10);
    // R11: selected, nothing committed yet
    check("R11 width held", 32'(width), 32'h A6);
    shift_bits(8, 32'h0000_0044);
    waitc(10);
    check("R11 period held", 32'(period), 32'h05);
    cs_n = 1'b1;
    waitc(8);
    check("R4 after release period", 32'(period), 32'h33);
    check("R4 after release width", 32'(width), 32'h44);
  endtask

  task automatic t_power_down;
    send(24, 32'h0002_1020);
    // R7 R9
    expect_regs("R9 set", 1'b0, 1'b1, 8'h10, 8'h20);
    send(16, 32'h0000_0000);
    expect_regs("R9 16 keeps", 1'b0, 1'b1, 8'h00, 8'h00);
    send(8, 32'h0000_0055);
    expect_regs("R9 8 keeps", 1'b0, 1'b1, 8'h00, 8'h55);
    send(24, 32'h0001_3C0F);
    expect_regs("R9 full clears", 1'b1, 1'b0, 8'h3C, 8'h0F);
  endtask

  initial begin
    fork
      begin
        waitc(3);
        rst_n = 1'b1;
        waitc(3);
        t_reset();
        t_short_before_full();
        t_full();
        t_width_only();
        t_bad_lengths();
        t_mid_transfer();
        t_power_down();
        // R10: strobe never longer than one cycle
        check("R10 strobe width", 32'(stb_long), 0);
      end
      begin
        waitc(100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule